// File: doc/BRIEF.md
# Round-Iterative Block Cipher Sequencer

This block is the control half of a round-iterative 64-bit block cipher engine that uses a 128-bit master key. It does not touch key or text data. Instead it tells a separate datapath when to load the key schedule, when to apply input whitening, which of the 32 rounds to execute on each clock, and when the result is final. It also tells the surrounding logic when a new block may be submitted and when a result is waiting.

A host first requests key configuration by pulling the active-low key request line low for a few cycles. When the line goes high again, the sequencer raises its ready flag. A single-cycle text-valid pulse while ready starts a block. At that moment the direction bit is captured: 0 means encrypt and 1 means decrypt. The sequencer then spends one cycle on whitening and 32 cycles on rounds. After that it holds a done flag until the downstream consumer signals that it can take the result. It then returns to ready, and further blocks can run under the same key without another configuration.

A text-valid pulse that arrives during key configuration is treated as a protocol error. The error state is sticky until a new key request arrives or the block is reset.

Top module: `blk_round_seq`

## Requirements
- R1: While reset is asserted, and in the idle state after it, every output flag and strobe is 0, round_idx is 0 and op_dec_q is 0.
- R2: From idle, key_req_n low moves the block to key configuration (key_cfg high) on the next edge. It stays there while key_req_n is low, and moves to ready (rdy high) on the first edge with key_req_n high.
- R3: The flags rdy, text_done, load, round_en, key_cfg and err are never high together. rdy is high only in the ready state.
- R4: A text_vld pulse sampled in ready, with key_req_n high, gives load high for exactly the next cycle. op_dec_q takes the value of op_sel sampled at that edge (0 encrypt, 1 decrypt) and holds it until the next start.
- R5: After load, round_en is high for 32 consecutive cycles with round_idx counting 0, 1, …, 31.
- R6: finalize is high only in the cycle with round_idx 31. text_done rises 33 cycles after the start edge.
- R7: While text_done is high and post_rdy is low, text_done stays high. The first edge with post_rdy high returns the block to ready.
- R8: After a completed block, a second block runs without a new key configuration and follows the same timing.
- R9: text_vld is ignored during whitening, rounds and the done state. The round sequence and the done hold are unchanged.
- R10: text_vld during key configuration moves the block to err. err stays high while key_req_n is high, and key_req_n low moves it back to key configuration.
- R11: In ready, key_req_n low moves the block to key configuration even if text_vld is high in the same cycle.
- R12: key_req_n low during rounds has no effect on the round sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_req_n | input | 1 | Active-low key configuration request |
| text_vld | input | 1 | One-cycle pulse that starts a block |
| op_sel | input | 1 | Direction: 0 encrypt, 1 decrypt |
| post_rdy | input | 1 | Downstream consumer can accept the result |
| rdy | output | 1 | Ready for a new block |
| text_done | output | 1 | Result is complete and held |
| key_cfg | output | 1 | Key configuration in progress (key schedule load strobe) |
| load | output | 1 | Whitening / text load strobe |
| round_en | output | 1 | Round function enable |
| round_idx | output | 5 | Index of the round being executed |
| finalize | output | 1 | Last-round strobe |
| op_dec_q | output | 1 | Latched direction of the current block |
| err | output | 1 | Protocol error state |

## Verification
Every phase of the controller drives its own flag, so a corrupted state register shows up at the ports as a different flag, or as two flags at once, on the sample just after the faulty edge. A counter that skips or stalls changes round_idx or finalize in that same cycle. The done state also appears one cycle early or late, so a wrong round count cannot hide for more than one block. Comparing the full output vector every cycle against an independent expected sequence therefore pins any divergence to the exact clock where it first happens.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_KEYCFG = 3'd1,
    PH_READY  = 3'd2,
    PH_WHITEN = 3'd3,
    PH_ROUND  = 3'd4,
    PH_DONE   = 3'd5,
    PH_ERROR  = 3'd6
  } phase_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES clean edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/seq_round_ctr.sv
module seq_round_ctr #(
  parameter int ROUNDS = 32,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = run || (idx_q != '0);
    if (run && (idx_q != LAST_IDX)) idx_d = idx_q + 1'b1;
    else                            idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign last = run && (idx_q == LAST_IDX);

  // R5: while running and not at the end, the index advances by one
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (idx == $past(idx) + 1'b1));

  // R5: counter rests at zero when not running
  a_r5_idx_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (idx == '0));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   key_req_n,
  input  logic   text_vld,
  input  logic   post_rdy,
  input  logic   op_sel,
  input  logic   last_round,
  output phase_e phase,
  output logic   op_q
);

  phase_e ph_q;
  phase_e ph_d;
  logic   start;
  logic   op_d;

  assign start = (ph_q == PH_READY) && key_req_n && text_vld;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (!key_req_n) ph_d = PH_KEYCFG;
      PH_KEYCFG: begin
        if (text_vld)      ph_d = PH_ERROR;
        else if (key_req_n) ph_d = PH_READY;
      end
      PH_READY: begin
        if (!key_req_n)    ph_d = PH_KEYCFG;
        else if (text_vld) ph_d = PH_WHITEN;
      end
      PH_WHITEN: ph_d = PH_ROUND;
      PH_ROUND:  if (last_round) ph_d = PH_DONE;
      PH_DONE:   if (post_rdy) ph_d = PH_READY;
      PH_ERROR:  if (!key_req_n) ph_d = PH_KEYCFG;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign op_d = op_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= 1'b0;
    end else if (start) begin
      op_q <= op_d;
    end
  end

  assign phase = ph_q;

  // R10: the error state is only left through a key request
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ERROR && key_req_n) |=> (ph_q == PH_ERROR));

  // R12: a round in progress always continues to the next phase in sequence
  a_r12_round_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ROUND) |=> (ph_q == PH_ROUND || ph_q == PH_DONE));

  // R4: the direction is frozen after a start until the next start
  a_r4_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_READY) |=> $stable(op_q));

endmodule

// File: rtl/blk_round_seq.sv
module blk_round_seq
  import seq_pkg::*;
#(
  parameter int ROUNDS      = 32,
  parameter int IDX_W       = $clog2(ROUNDS),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_req_n,
  input  logic             text_vld,
  input  logic             op_sel,
  input  logic             post_rdy,
  output logic             rdy,
  output logic             text_done,
  output logic             key_cfg,
  output logic             load,
  output logic             round_en,
  output logic [IDX_W-1:0] round_idx,
  output logic             finalize,
  output logic             op_dec_q,
  output logic             err
);

  logic   srst_n;
  phase_e phase;
  logic   run;
  logic   last;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .key_req_n  (key_req_n),
    .text_vld   (text_vld),
    .post_rdy   (post_rdy),
    .op_sel     (op_sel),
    .last_round (last),
    .phase      (phase),
    .op_q       (op_dec_q)
  );

  assign run = (phase == PH_ROUND);

  seq_round_ctr #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) u_ctr (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (run),
    .idx   (round_idx),
    .last  (last)
  );

  // Per-phase strobes decoded from the phase register
  assign rdy       = (phase == PH_READY);
  assign text_done = (phase == PH_DONE);
  assign key_cfg   = (phase == PH_KEYCFG);
  assign load      = (phase == PH_WHITEN);
  assign round_en  = run;
  assign finalize  = last;
  assign err       = (phase == PH_ERROR);

  // R3: phase flags mutually exclusive
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({rdy, text_done, key_cfg, load, round_en, err}));

  // R4/R5: whitening lasts one cycle and is followed by round 0
  a_r5_load_then_round0: assert property (@(posedge clk) disable iff (!srst_n)
    load |=> (round_en && round_idx == '0 && !load));

  // R6: the last round leads to done
  a_r6_final_to_done: assert property (@(posedge clk) disable iff (!srst_n)
    finalize |=> text_done);

  // R6: finalize only during a round
  a_r6_final_in_round: assert property (@(posedge clk) disable iff (!srst_n)
    finalize |-> round_en);

  // R7: the result is held under back-pressure
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (text_done && !post_rdy) |=> text_done);

  // R7: release returns to ready
  a_r7_done_release: assert property (@(posedge clk) disable iff (!srst_n)
    (text_done && post_rdy) |=> rdy);

  // R11: key request in ready wins over text_vld
  a_r11_key_priority: assert property (@(posedge clk) disable iff (!srst_n)
    (rdy && !key_req_n) |=> key_cfg);

endmodule

// File: tb/blk_round_seq_bench.sv
`timescale 1ns/1ps
module blk_round_seq_bench;

  localparam int ROUNDS = 32;

  localparam logic [6:0] E_NONE = 7'b0000000;
  localparam logic [6:0] E_RDY  = 7'b1000000;
  localparam logic [6:0] E_DONE = 7'b0100000;
  localparam logic [6:0] E_KCFG = 7'b0010000;
  localparam logic [6:0] E_LOAD = 7'b0001000;
  localparam logic [6:0] E_RND  = 7'b0000100;
  localparam logic [6:0] E_FIN  = 7'b0000010;
  localparam logic [6:0] E_ERR  = 7'b0000001;

  typedef struct {
    logic [6:0] flags;
    int         idx;
    logic       op;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       key_req_n;
  logic       text_vld;
  logic       op_sel;
  logic       post_rdy;
  logic       rdy, text_done, key_cfg, load, round_en, finalize, op_dec_q, err;
  logic [4:0] round_idx;

  int   n_checks = 0;
  int   n_fail   = 0;
  logic cur_op   = 1'b0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  blk_round_seq u_blk_round_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_req_n (key_req_n),
    .text_vld  (text_vld),
    .op_sel    (op_sel),
    .post_rdy  (post_rdy),
    .rdy       (rdy),
    .text_done (text_done),
    .key_cfg   (key_cfg),
    .load      (load),
    .round_en  (round_en),
    .round_idx (round_idx),
    .finalize  (finalize),
    .op_dec_q  (op_dec_q),
    .err       (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] obs_flags();
    return {rdy, text_done, key_cfg, load, round_en, finalize, err};
  endfunction

  // Monitor: compares the outputs just after each rising edge with the queue head
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (obs_flags() !== e.flags || round_idx !== e.idx[4:0] || op_dec_q !== e.op) begin
          n_fail++;
          $display("FAIL %s: flags=%b idx=%0d op=%b expected flags=%b idx=%0d op=%b",
                   e.req, obs_flags(), round_idx, op_dec_q, e.flags, e.idx, e.op);
        end
      end
    end
  end

  // Driver: drive inputs for the next edge, push the expected post-edge outputs
  task automatic step(input logic kn, input logic tv, input logic op, input logic pr,
                      input logic [6:0] ef, input int ei, input string rq);
    exp_t e;
    key_req_n = kn;
    text_vld  = tv;
    op_sel    = op;
    post_rdy  = pr;
    e.flags = ef;
    e.idx   = ei;
    e.op    = cur_op;
    e.req   = rq;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic key_config(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, 1'b0, 1'b1, E_KCFG, 0, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b1, E_RDY, 0, "R2");
  endtask

  // One block: start, whitening, 32 rounds, done with 'stall' cycles of back-pressure
  task automatic run_block(input logic op, input int stall, input string rq);
    cur_op = op;
    step(1'b1, 1'b1, op, 1'b1, E_LOAD, 0, "R4");
    for (int i = 0; i < ROUNDS; i++) begin
      // R9: stray text_vld in a round; R12: key request in a round
      step((i == 10) ? 1'b0 : 1'b1, (i == 5) ? 1'b1 : 1'b0, ~op, 1'b1,
           (i == ROUNDS-1) ? (E_RND | E_FIN) : E_RND, i,
           (i == ROUNDS-1) ? "R6" : (i == 10 ? "R12" : (i == 5 ? "R9" : "R5")));
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, E_DONE, 0, "R6");
    for (int i = 0; i < stall; i++)
      step(1'b1, (i == 0) ? 1'b1 : 1'b0, 1'b0, 1'b0, E_DONE, 0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b1, E_RDY, 0, rq);
  endtask

  initial begin
    rst_n = 1'b0;
    key_req_n = 1'b1;
    text_vld = 1'b0;
    op_sel = 1'b0;
    post_rdy = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    n_checks++;
    if (obs_flags() !== E_NONE || round_idx !== 5'd0 || op_dec_q !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: flags=%b idx=%0d op=%b expected flags=%b idx=0 op=0",
               obs_flags(), round_idx, op_dec_q, E_NONE);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b1, E_NONE, 0, "R1");

    key_config(4);
    run_block(1'b0, 0, "R7");
    run_block(1'b0, 4, "R8");

    // R11: key request with a simultaneous text_vld in ready
    step(1'b0, 1'b1, 1'b0, 1'b1, E_KCFG, 0, "R11");
    // R10: text_vld during key configuration
    step(1'b0, 1'b1, 1'b0, 1'b1, E_ERR, 0, "R10");
    for (int i = 0; i < 3; i++) step(1'b1, (i == 1) ? 1'b1 : 1'b0, 1'b0, 1'b1, E_ERR, 0, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b1, E_KCFG, 0, "R10");
    key_config(2);

    run_block(1'b1, 2, "R8");
    run_block(1'b0, 1, "R4");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule